// File: doc/BRIEF.md
# Packed Lane Duplicate Unit

This block takes a 128-bit source vector together with a 2-bit operation code and produces a 128-bit result in which selected source lanes are replicated across the destination. Three fixed patterns are available: the odd-indexed 32-bit lanes copied down into their even neighbours, the even-indexed 32-bit lanes copied up into their odd neighbours, and the low 64-bit element broadcast to both 64-bit halves. A plain pass-through copy completes the opcode space.

The result passes through one register stage. An operation may be presented on every clock, and each accepted operation yields exactly one result-valid pulse one clock later. While no operation is presented, the registered result keeps its last value. The lane pattern depends only on the opcode. The block is not a general shuffle with a control immediate.

Top module: `lane_dup_unit`

## Requirements
- R1: Opcode 2'b00 (copy) yields a result equal to the source, bit for bit. Lane k occupies bits 32k+31:32k, so lane 0 is bits 31:0 and lane 3 is bits 127:96.
- R2: Opcode 2'b01 (odd duplicate) yields result lanes {3,2,1,0} = {s3, s3, s1, s1}, where s0..s3 are the 32-bit source lanes.
- R3: Opcode 2'b10 (even duplicate) yields result lanes {3,2,1,0} = {s2, s2, s0, s0}.
- R4: Opcode 2'b11 (wide duplicate) places source bits 63:0 in both result bits 63:0 and 127:64. Source bits 127:64 have no effect on the result.
- R5: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high outside reset. Back-to-back operations on consecutive cycles each produce their own result.
- R6: While `rst` is high at a clock edge, `out_valid` and `out_result` clear to zero on that edge. An `in_valid` presented during reset produces no result.
- R7: While `in_valid` is low, `out_result` holds its previous value whatever `in_op` and `in_src` carry, and `out_valid` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 2 | Operation code: 00 copy, 01 odd duplicate, 10 even duplicate, 11 wide duplicate |
| in_src | input | 128 | Source vector, lane 0 in bits 31:0 |
| out_valid | output | 1 | Result register holds a fresh result |
| out_result | output | 128 | Registered result vector |

## Verification
Every result is due exactly one rising edge after its operation is presented. The bench drives inputs on the falling edge and reads outputs on the next falling edge, half a period after the capturing edge. In the table-driven run a new operation is presented on every falling edge, and the output read at that same falling edge is compared against the previous table row before the next row is driven. Hold and reset checks are made on the falling edges one and two cycles after the stimulus, because at those edges a faulty design would already show the changed value.

// File: rtl/lane_dup_pkg.sv
package lane_dup_pkg;

  typedef enum logic [1:0] {
    OP_COPY     = 2'b00,
    OP_ODD_DUP  = 2'b01,
    OP_EVEN_DUP = 2'b10,
    OP_WIDE_DUP = 2'b11
  } dup_op_e;

  // Number of 32-bit lanes that make up one 64-bit element
  localparam int unsigned WIDE_GROUP = 2;

endpackage

// File: rtl/lane_dup_select.sv
module lane_dup_select
  import lane_dup_pkg::*;
#(
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned VEC_W    = LANE_W * NUM_LANES,
  localparam int unsigned IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  dup_op_e          op,
  input  logic [VEC_W-1:0] src,
  output logic [VEC_W-1:0] dst
);

  // Which source lane feeds destination lane `pos` for operation `o`
  function automatic logic [IDX_W-1:0] src_lane_for(input dup_op_e o,
                                                    input int unsigned pos);
    int unsigned idx;
    case (o)
      OP_ODD_DUP:  idx = pos | 1;
      OP_EVEN_DUP: idx = pos & ~32'd1;
      OP_WIDE_DUP: idx = pos % WIDE_GROUP;
      default:     idx = pos;
    endcase
    return idx[IDX_W-1:0];
  endfunction

  logic [LANE_W-1:0] src_lane [NUM_LANES];
  logic [LANE_W-1:0] dst_lane [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign src_lane[g] = src[g*LANE_W +: LANE_W];

    always_comb begin
      dst_lane[g] = src_lane[src_lane_for(op, g)];
    end

    assign dst[g*LANE_W +: LANE_W] = dst_lane[g];
  end

  // Pairwise lane relations that each pattern must exhibit
  for (genvar p = 0; p + 1 < NUM_LANES; p += 2) begin : g_pair_chk
    always_comb begin
      if (op == OP_ODD_DUP) begin
        assert_odd_pair_R2: assert (dst_lane[p] == src_lane[p+1] && dst_lane[p+1] == src_lane[p+1]);
      end
      if (op == OP_EVEN_DUP) begin
        assert_even_pair_R3: assert (dst_lane[p] == src_lane[p] && dst_lane[p+1] == src_lane[p]);
      end
      if (op == OP_WIDE_DUP) begin
        assert_wide_pair_R4: assert (dst_lane[p] == src_lane[0] && dst_lane[p+1] == src_lane[1]);
      end
      if (op == OP_COPY) begin
        assert_copy_pair_R1: assert (dst_lane[p] == src_lane[p] && dst_lane[p+1] == src_lane[p+1]);
      end
    end
  end

endmodule

// File: rtl/lane_dup_stage.sv
module lane_dup_stage #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);

  logic capture;
  assign capture = in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (capture) begin
        out_data <= in_data;
      end
    end
  end

  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

endmodule

// File: rtl/lane_dup_unit.sv
module lane_dup_unit
  import lane_dup_pkg::*;
#(
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned VEC_W    = LANE_W * NUM_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [VEC_W-1:0] in_src,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result
);

  dup_op_e          op_dec;
  logic [VEC_W-1:0] dup_next;

  assign op_dec = dup_op_e'(in_op);

  lane_dup_select #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES)
  ) u_select (
    .op  (op_dec),
    .src (in_src),
    .dst (dup_next)
  );

  lane_dup_stage #(
    .WIDTH (VEC_W)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (dup_next),
    .out_valid (out_valid),
    .out_data  (out_result)
  );

  // A wide-duplicate result always has matching 64-bit halves one cycle on
  assert_wide_halves_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b11) |=> (out_result[VEC_W-1:VEC_W/2] == out_result[VEC_W/2-1:0]));

endmodule

// File: tb/lane_dup_unit_test.sv
`timescale 1ns/1ps
module lane_dup_unit_test;

  localparam int N = 8;

  localparam logic [127:0] SA = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
  localparam logic [127:0] SB = {32'h89ABCDEF, 32'h01234567, 32'hFFFFFFFF, 32'h00000000};

  localparam logic [1:0] T_OP [N] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b10, 2'b11, 2'b00};
  localparam logic [127:0] T_SRC [N] = '{SA, SA, SA, SA, SB, SB, SB, SB};
  localparam logic [127:0] T_EXP [N] = '{
    SA,
    {32'hDDDD0003, 32'hDDDD0003, 32'hBBBB0001, 32'hBBBB0001},
    {32'hCCCC0002, 32'hCCCC0002, 32'hAAAA0000, 32'hAAAA0000},
    {32'hBBBB0001, 32'hAAAA0000, 32'hBBBB0001, 32'hAAAA0000},
    {32'h89ABCDEF, 32'h89ABCDEF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {32'h01234567, 32'h01234567, 32'h00000000, 32'h00000000},
    {32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'h00000000},
    SB
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   in_op = 2'b00;
  logic [127:0] in_src = '0;
  logic         out_valid;
  logic [127:0] out_result;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lane_dup_unit uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_src     (in_src),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  function automatic string tag_for(input logic [1:0] op);
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // Reset with an operation pending: it must be ignored (R6)
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b00; in_src = SA;
    @(negedge clk);
    @(negedge clk);
    check("R6", {127'd0, out_valid}, 128'd0);
    check("R6", out_result, 128'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R6", {127'd0, out_valid}, 128'd0);

    // Table walk, one operation per cycle (R1..R5)
    for (int i = 0; i <= N; i++) begin
      if (i > 0) begin
        check("R5", {127'd0, out_valid}, 128'd1);
        check(tag_for(T_OP[i-1]), out_result, T_EXP[i-1]);
      end
      if (i < N) begin
        in_valid = 1'b1; in_op = T_OP[i]; in_src = T_SRC[i];
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    // One cycle after the last operation out_valid falls (R5)
    check("R5", {127'd0, out_valid}, 128'd0);

    // Upper half of source ignored by wide duplicate (R4)
    in_valid = 1'b1; in_op = 2'b11;
    in_src = {64'h5555AAAA5555AAAA, 32'h12345678, 32'h9ABCDEF0};
    @(negedge clk);
    check("R4", out_result, {32'h12345678, 32'h9ABCDEF0, 32'h12345678, 32'h9ABCDEF0});

    // Hold while idle, inputs changing (R7)
    in_valid = 1'b0; in_op = 2'b00; in_src = SB;
    @(negedge clk);
    check("R7", {127'd0, out_valid}, 128'd0);
    check("R7", out_result, {32'h12345678, 32'h9ABCDEF0, 32'h12345678, 32'h9ABCDEF0});
    in_op = 2'b01; in_src = SA;
    @(negedge clk);
    check("R7", out_result, {32'h12345678, 32'h9ABCDEF0, 32'h12345678, 32'h9ABCDEF0});

    // Single pulse gives a single valid (R5)
    in_valid = 1'b1; in_op = 2'b10; in_src = SB;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", {127'd0, out_valid}, 128'd1);
    check("R3", out_result, T_EXP[5]);
    @(negedge clk);
    check("R5", {127'd0, out_valid}, 128'd0);

    // Reset mid-stream clears (R6)
    in_valid = 1'b1; in_op = 2'b01; in_src = SA;
    rst = 1'b1;
    @(negedge clk);
    check("R6", {127'd0, out_valid}, 128'd0);
    check("R6", out_result, 128'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R6", {127'd0, out_valid}, 128'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule